// File: doc/BRIEF.md
# Branch Next-PC Unit

This unit owns the fetch address of a five-stage in-order pipeline and resolves conditional equality branches. Each cycle it offers the address the fetch stage will use next: the following sequential word, a branch target, or the current address held. The decode stage tells it when the instruction in decode is a branch and gives that branch's own address and its sign-extended byte offset. A separate input carries the equality result of the branch's two register operands. A freeze input from the hazard unit holds everything.

Three control-hazard policies are available, and one is chosen at reset. The stall policy issues no fetch until the decision is known. The predict policy keeps fetching sequentially and discards the wrong-path instructions when the branch is taken. The delay-slot policy always executes the one instruction after the branch and redirects after it. A build parameter sets where the equality result becomes available. In the decode stage it arrives in the same cycle the branch is signalled. In the execute stage it arrives one cycle later, and every penalty then grows by one cycle.

Top module: `npc_branch_unit`

## Requirements
- R1: While reset is asserted, fetch_pc equals RESET_PC (0 by default), next_pc equals RESET_PC+4, and fetch_stall, squash_fetch and squash_dec are all low.
- R2: In a cycle with no branch resolving or waiting and no freeze, next_pc equals fetch_pc+4, and fetch_pc takes the value of next_pc at the next rising edge.
- R3: A branch is taken when op_equal is high at its resolution. Its target is its own address plus the offset, with the offset read as a two's-complement byte count. A not-taken branch continues at its own address plus 4.
- R4: In stall policy, every accepted branch raises fetch_stall for one cycle when resolved in decode and for two cycles when resolved in execute, whatever the outcome. fetch_pc then moves to the target or to the branch address plus 4, and no squash is raised. During the first stall cycle of execute resolution, next_pc holds fetch_pc.
- R5: In predict policy, a branch that is not taken costs nothing: there is no stall and no squash, and fetch continues sequentially.
- R6: In predict policy, a taken branch raises squash_fetch in its resolution cycle and sets next_pc to the target. With execute resolution it also raises squash_dec, because the instruction in decode is on the wrong path as well.
- R7: In delay-slot policy, the instruction after the branch is never stalled or squashed, and redirection to the target happens after it. With decode resolution a taken branch raises no squash. With execute resolution it raises squash_fetch only, for the instruction two words past the branch.
- R8: While freeze is high, next_pc equals fetch_pc, all stall and squash outputs are low, and any branch decision waits for the first cycle without freeze.
- R9: The policy is taken from mode_sel at the first rising edge after reset. Changes to mode_sel after that edge have no effect until the next reset.
- R10: dec_branch is ignored when the decode slot holds a stalled or squashed bubble. Such a cycle gives next_pc = fetch_pc+4 and no stall or squash.
- R11: mode_sel encodes 00 as stall, 01 as predict, 10 as delay slot, and 11 also as stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Policy select, latched after reset |
| freeze | input | 1 | Hazard-unit hold of the front end |
| dec_branch | input | 1 | Instruction in decode is a conditional branch |
| dec_pc | input | AW | Address of the instruction in decode |
| dec_offset | input | AW | Sign-extended byte offset of that branch |
| op_equal | input | 1 | Operand equality for the resolving branch |
| fetch_pc | output | AW | Address being fetched this cycle |
| next_pc | output | AW | Address to fetch next cycle |
| fetch_stall | output | 1 | This cycle's fetch is not issued |
| squash_fetch | output | 1 | Clear the valid bit of the instruction in fetch |
| squash_dec | output | 1 | Clear the valid bit of the instruction in decode |

## Verification
next_pc, fetch_stall and the squash outputs depend on the inputs of the same cycle. fetch_pc shows the result one rising edge later. With execute resolution, op_equal is due one cycle after the branch is seen in decode, and the stall and squash results appear in that later cycle. The bench drives inputs on the falling edge and compares every output 1 ns later against an expected-value model. That model advances only at the rising edge, so each check lands in the cycle in which the result is due.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [1:0] {
    POL_STALL   = 2'b00,
    POL_PREDICT = 2'b01,
    POL_DELAY   = 2'b10,
    POL_SPARE   = 2'b11
  } policy_e;

  // R11: the spare code behaves as the stall policy
  function automatic policy_e norm_policy(input logic [1:0] code);
    if (code == 2'b11) begin
      return POL_STALL;
    end
    return policy_e'(code);
  endfunction

endpackage

// File: rtl/npc_adders.sv
module npc_adders #(
  parameter int unsigned AW         = 32,
  parameter int unsigned INSN_BYTES = 4
) (
  input  logic [AW-1:0] cur_pc,
  input  logic [AW-1:0] br_pc,
  input  logic [AW-1:0] br_off,
  output logic [AW-1:0] seq_pc,
  output logic [AW-1:0] br_fall,
  output logic [AW-1:0] br_tgt
);
  localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);

  always_comb begin
    seq_pc  = cur_pc + STEP;
    br_fall = br_pc + STEP;
    br_tgt  = br_pc + br_off;
  end
endmodule

// File: rtl/npc_ex_stage.sv
module npc_ex_stage #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          dec_take,
  input  logic          dec_kill,
  input  logic [AW-1:0] dec_pc,
  input  logic [AW-1:0] dec_off,
  output logic          ex_valid,
  output logic [AW-1:0] ex_pc,
  output logic [AW-1:0] ex_off,
  output logic          waiting
);
  logic          vld_q, vld_d;
  logic [AW-1:0] pc_q, pc_d;
  logic [AW-1:0] off_q, off_d;

  always_comb begin
    waiting = dec_take & ~dec_kill;
    vld_d   = vld_q;
    pc_d    = pc_q;
    off_d   = off_q;
    if (adv) begin
      vld_d = waiting;
      pc_d  = dec_pc;
      off_d = dec_off;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      pc_q  <= '0;
      off_q <= '0;
    end else begin
      vld_q <= vld_d;
      pc_q  <= pc_d;
      off_q <= off_d;
    end
  end

  assign ex_valid = vld_q;
  assign ex_pc    = pc_q;
  assign ex_off   = off_q;

  AST_EX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> vld_q == $past(vld_q)) else $error("ex stage moved under freeze"); // R8
endmodule

// File: rtl/npc_policy.sv
module npc_policy
  import npc_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter bit          LATE = 1'b1
) (
  input  policy_e       pol,
  input  logic          frz,
  input  logic          rs_valid,
  input  logic          rs_equal,
  input  logic          waiting,
  input  logic [AW-1:0] cur_pc,
  input  logic [AW-1:0] seq_pc,
  input  logic [AW-1:0] br_fall,
  input  logic [AW-1:0] br_tgt,
  output logic [AW-1:0] npc,
  output logic          stall,
  output logic          sq_fetch,
  output logic          sq_dec
);
  logic taken;

  always_comb begin
    taken    = rs_valid & rs_equal;
    npc      = seq_pc;
    stall    = 1'b0;
    sq_fetch = 1'b0;
    sq_dec   = 1'b0;
    unique case (pol)
      POL_PREDICT: begin
        if (taken) begin
          npc      = br_tgt;
          sq_fetch = 1'b1;
          sq_dec   = LATE;
        end
      end
      POL_DELAY: begin
        if (taken) begin
          npc      = br_tgt;
          sq_fetch = LATE;
        end
      end
      default: begin
        if (rs_valid) begin
          stall = 1'b1;
          npc   = taken ? br_tgt : br_fall;
        end else if (waiting) begin
          stall = 1'b1;
          npc   = cur_pc;
        end
      end
    endcase
    if (frz) begin
      npc      = cur_pc;
      stall    = 1'b0;
      sq_fetch = 1'b0;
      sq_dec   = 1'b0;
    end
  end

  always_comb begin
    AST_NO_STALL_AND_SQUASH: assert (!(stall && sq_fetch)) else $error("stall with squash"); // R4
  end
endmodule

// File: rtl/npc_branch_unit.sv
module npc_branch_unit
  import npc_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter logic [AW-1:0] RESET_PC = '0,
  parameter bit          RESOLVE_EX = 1'b1,
  parameter int unsigned INSN_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_sel,
  input  logic          freeze,
  input  logic          dec_branch,
  input  logic [AW-1:0] dec_pc,
  input  logic [AW-1:0] dec_offset,
  input  logic          op_equal,
  output logic [AW-1:0] fetch_pc,
  output logic [AW-1:0] next_pc,
  output logic          fetch_stall,
  output logic          squash_fetch,
  output logic          squash_dec
);
  logic          boot_q, boot_d;
  logic [1:0]    mode_q, mode_d;
  logic          dv_q, dv_d;
  logic [AW-1:0] pc_q, pc_d;
  policy_e       pol;
  logic          adv, dec_take;
  logic          rs_valid, waiting;
  logic [AW-1:0] rs_pc, rs_off;
  logic [AW-1:0] seq_pc, br_fall, br_tgt, npc;
  logic          stall_w, sqf_w, sqd_w;

  assign adv      = ~freeze;
  assign pol      = norm_policy(boot_q ? mode_sel : mode_q);
  assign dec_take = dec_branch & dv_q;   // R10: bubbles never resolve

  generate
    if (RESOLVE_EX) begin : g_late
      npc_ex_stage #(.AW(AW)) u_ex (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .dec_take (dec_take),
        .dec_kill (sqd_w),
        .dec_pc   (dec_pc),
        .dec_off  (dec_offset),
        .ex_valid (rs_valid),
        .ex_pc    (rs_pc),
        .ex_off   (rs_off),
        .waiting  (waiting)
      );
    end else begin : g_early
      assign rs_valid = dec_take;
      assign rs_pc    = dec_pc;
      assign rs_off   = dec_offset;
      assign waiting  = 1'b0;
    end
  endgenerate

  npc_adders #(.AW(AW), .INSN_BYTES(INSN_BYTES)) u_add (
    .cur_pc  (pc_q),
    .br_pc   (rs_pc),
    .br_off  (rs_off),
    .seq_pc  (seq_pc),
    .br_fall (br_fall),
    .br_tgt  (br_tgt)
  );

  npc_policy #(.AW(AW), .LATE(RESOLVE_EX)) u_pol (
    .pol      (pol),
    .frz      (freeze),
    .rs_valid (rs_valid),
    .rs_equal (op_equal),
    .waiting  (waiting),
    .cur_pc   (pc_q),
    .seq_pc   (seq_pc),
    .br_fall  (br_fall),
    .br_tgt   (br_tgt),
    .npc      (npc),
    .stall    (stall_w),
    .sq_fetch (sqf_w),
    .sq_dec   (sqd_w)
  );

  always_comb begin
    boot_d = 1'b0;
    mode_d = boot_q ? mode_sel : mode_q;
    pc_d   = npc;
    dv_d   = dv_q;
    if (adv) begin
      dv_d = ~(stall_w | sqf_w);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q <= 1'b1;
      mode_q <= 2'b00;
      pc_q   <= RESET_PC;
      dv_q   <= 1'b0;
    end else begin
      boot_q <= boot_d;
      mode_q <= mode_d;
      pc_q   <= pc_d;
      dv_q   <= dv_d;
    end
  end

  assign fetch_pc     = pc_q;
  assign next_pc      = npc;
  assign fetch_stall  = stall_w;
  assign squash_fetch = sqf_w;
  assign squash_dec   = sqd_w;

  AST_PC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !freeze |=> fetch_pc == $past(next_pc)) else $error("pc did not follow"); // R2
  AST_FREEZE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> (next_pc == fetch_pc) && !fetch_stall && !squash_fetch && !squash_dec)
    else $error("activity under freeze"); // R8
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_q |=> mode_q == $past(mode_q)) else $error("policy changed"); // R9
  AST_STALL_NO_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
    pol == POL_STALL |-> !squash_fetch && !squash_dec) else $error("squash in stall policy"); // R4
  AST_PREDICT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    pol == POL_PREDICT |-> !fetch_stall) else $error("stall in predict policy"); // R5
  AST_DEC_SQUASH_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    squash_dec |-> squash_fetch) else $error("lone decode squash"); // R6
  AST_SLOT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    pol == POL_DELAY |-> !squash_dec && !fetch_stall) else $error("delay slot lost"); // R7
  AST_BUBBLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!RESOLVE_EX && !dv_q && !freeze) |-> next_pc == fetch_pc + AW'(INSN_BYTES) && !fetch_stall)
    else $error("bubble resolved"); // R10
endmodule

// File: tb/test_npc_branch_unit.sv
module test_npc_branch_unit;
  localparam int CYC = 2500;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  msel;
  logic        fr, eq;
  logic [31:0] off;
  logic        db   [2];
  logic [31:0] dpc  [2];
  logic [31:0] fpc  [2];
  logic [31:0] npc  [2];
  logic        st   [2];
  logic        sqf  [2];
  logic        sqd  [2];

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // model state, lane 0 resolves in execute, lane 1 in decode
  logic [31:0] m_pc [2], m_dpc [2], m_expc [2], m_exoff [2], e_n [2];
  logic        m_dv [2], m_exb [2], m_slot [2], e_st [2], e_sf [2], e_pend [2], e_take [2];
  logic        m_boot;
  logic [1:0]  m_mode;

  always #2 clk = ~clk;

  npc_branch_unit #(.RESOLVE_EX(1'b1)) i_npc_branch_unit (
    .clk(clk), .rst_n(rst_n), .mode_sel(msel), .freeze(fr), .dec_branch(db[0]),
    .dec_pc(dpc[0]), .dec_offset(off), .op_equal(eq), .fetch_pc(fpc[0]), .next_pc(npc[0]),
    .fetch_stall(st[0]), .squash_fetch(sqf[0]), .squash_dec(sqd[0]));

  npc_branch_unit #(.RESOLVE_EX(1'b0)) i_npc_branch_unit_dec (
    .clk(clk), .rst_n(rst_n), .mode_sel(msel), .freeze(fr), .dec_branch(db[1]),
    .dec_pc(dpc[1]), .dec_offset(off), .op_equal(eq), .fetch_pc(fpc[1]), .next_pc(npc[1]),
    .fetch_stall(st[1]), .squash_fetch(sqf[1]), .squash_dec(sqd[1]));

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [1:0] eff_mode();
    logic [1:0] m = m_boot ? msel : m_mode;
    return (m == 2'b11) ? 2'b00 : m;
  endfunction

  // expected outputs of lane k from the requirements
  task automatic model_check(input int k, input int ph);
    logic       ex = (k == 0);
    logic [1:0] pm = eff_mode();
    logic       take = db[k] && m_dv[k];
    logic       rsv = ex ? m_exb[k] : take;
    logic [31:0] rpc = ex ? m_expc[k] : dpc[k];
    logic [31:0] roff = ex ? m_exoff[k] : off;
    logic       tk = rsv && eq;
    logic       sd = 1'b0;
    string      tag, ntag;
    e_n[k] = m_pc[k] + 32'd4; e_st[k] = 1'b0; e_sf[k] = 1'b0;
    case (pm)
      2'b01: if (tk) begin e_n[k] = rpc + roff; e_sf[k] = 1'b1; sd = ex; end
      2'b10: if (tk) begin e_n[k] = rpc + roff; e_sf[k] = ex; end
      default: begin
        if (rsv) begin e_st[k] = 1'b1; e_n[k] = tk ? rpc + roff : rpc + 32'd4; end
        else if (ex && take) begin e_st[k] = 1'b1; e_n[k] = m_pc[k]; end
      end
    endcase
    e_pend[k] = ex && take && !sd;
    e_take[k] = take;
    if (fr) begin e_n[k] = m_pc[k]; e_st[k] = 1'b0; e_sf[k] = 1'b0; sd = 1'b0; end
    if (fr) tag = "R8";
    else if (db[k] && !m_dv[k] && !rsv) tag = "R10";
    else if (!m_boot && msel != m_mode && (rsv || take)) tag = "R9";
    else if (rsv || take) begin
      if (ph == 3) tag = "R11";
      else if (pm == 2'b00) tag = "R4";
      else if (pm == 2'b01) tag = tk ? "R6" : "R5";
      else tag = "R7";
    end else tag = "R2";
    ntag = (tk && !fr) ? "R3" : tag;
    chk(tag, "fetch_pc", fpc[k], m_pc[k]);
    chk(ntag, "next_pc", npc[k], e_n[k]);
    chk(tag, "fetch_stall", 32'(st[k]), 32'(e_st[k]));
    chk(tag, "squash_fetch", 32'(sqf[k]), 32'(e_sf[k]));
    chk(tag, "squash_dec", 32'(sqd[k]), 32'(sd));
  endtask

  task automatic model_step();
    for (int k = 0; k < 2; k++) begin
      if (!fr) begin
        m_dpc[k]   = m_pc[k];
        m_pc[k]    = e_n[k];
        m_dv[k]    = !(e_st[k] || e_sf[k]);
        m_exb[k]   = e_pend[k];
        m_expc[k]  = dpc[k];
        m_exoff[k] = off;
        m_slot[k]  = e_take[k];
      end
    end
    if (m_boot) m_mode = msel;
    m_boot = 1'b0;
  endtask

  initial begin : watchdog
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; msel = 2'b00; fr = 1'b0; eq = 1'b0; off = '0;
    for (int k = 0; k < 2; k++) begin db[k] = 1'b0; dpc[k] = '0; end
    for (int ph = 0; ph < 4; ph++) begin
      @(negedge clk);
      rst_n = 1'b0; msel = 2'(ph); fr = 1'b0;
      for (int k = 0; k < 2; k++) db[k] = 1'b0;
      repeat (3) @(negedge clk);
      for (int k = 0; k < 2; k++) begin  // R1
        chk("R1", "reset fetch_pc", fpc[k], 32'h0);
        chk("R1", "reset next_pc", npc[k], 32'h4);
        chk("R1", "reset stall/squash", 32'({st[k], sqf[k], sqd[k]}), 32'h0);
      end
      rst_n = 1'b1;
      m_boot = 1'b1; m_mode = 2'b00;
      for (int k = 0; k < 2; k++) begin
        m_pc[k] = '0; m_dpc[k] = '0; m_dv[k] = 1'b0; m_exb[k] = 1'b0;
        m_expc[k] = '0; m_exoff[k] = '0; m_slot[k] = 1'b0;
      end
      for (int c = 0; c < CYC; c++) begin
        msel = m_boot ? 2'(ph) : 2'($urandom_range(0, 3));
        fr   = (c > 4) && ($urandom_range(0, 9) == 0);
        eq   = 1'($urandom_range(0, 1));
        off  = 32'(($signed($urandom_range(0, 128)) - 64) * 4);
        if (c == 20) begin off = 32'hFFFF_FFF0; eq = 1'b1; end  // R3 negative offset
        for (int k = 0; k < 2; k++) begin
          db[k]  = ($urandom_range(0, 2) == 0) && !(eff_mode() == 2'b10 && m_slot[k]);
          if (c == 20) db[k] = !(eff_mode() == 2'b10 && m_slot[k]);
          dpc[k] = m_dpc[k];
        end
        #1;
        for (int k = 0; k < 2; k++) model_check(k, ph);
        @(posedge clk);
        model_step();
        @(negedge clk);
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule